// File: doc/BRIEF.md
# 16-bit Multicycle Load-Store Processor Core

This block is a compact 16-bit processor core. The program counter, the data words and the instructions are all 16 bits wide. The core has sixteen general registers. Each instruction runs as a short sequence of clocked steps: fetch, register read, execute, an optional memory step and an optional register write. Each instruction class uses only the steps it needs. A single word-addressed memory port carries both instruction fetches and data accesses. The memory is synchronous: read data for an address presented in one cycle is available in the next cycle.

Every instruction holds a 4-bit opcode in bits 15:12 and three 4-bit fields: F2 in bits 11:8, F1 in bits 7:4 and F0 in bits 3:0. A debug port shows any register and the program counter. The core stops by itself when an instruction sends control back to its own address, which gives a test program a clean way to end.

Top module: `mini16_core`

## Requirements
- R1: While `rst` is high, the PC equals `RESET_PC`, all sixteen registers read 0 and `halted` is low. In the first cycle after reset is released, `mem_addr` equals `RESET_PC`.
- R2: The register ALU opcodes are ADD=0, SUB=1, AND=2, OR=3 and SLT=4. Each writes `reg[F2] = reg[F1] op reg[F0]`. SUB computes F1 minus F0. SLT writes 1 when F1 < F0 as signed values and 0 otherwise.
- R3: The immediate opcodes are ADDI=5, ANDI=6, ORI=7 and SLTI=8. Each writes `reg[F2] = reg[F1] op imm`, where `imm` is F0. ADDI and SLTI sign-extend F0. ANDI and ORI zero-extend it.
- R4: LW (opcode 9) reads the word at `reg[F1] + sext(F0)` and writes it into `reg[F2]`.
- R5: SW (opcode A) writes `reg[F2]` to `reg[F1] + sext(F0)`, with `mem_we` high for exactly one cycle.
- R6: BEQ (B) and BNE (C) compare `reg[F2]` with `reg[F1]`. When the condition holds, the PC becomes `address + 1 + sext(F0)`. When it does not hold, execution continues at `address + 1`.
- R7: SHIFT (D) writes `reg[F1]`, moved by one bit, into `reg[F2]`. The type in F0 selects the move: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate left, 4 rotate right. Any other type copies the value unchanged.
- R8: JAL (F) writes `address + 1` into register 15 and sets the PC to `{pc[15:12], bits 11:0}`, where `pc` is the incremented PC. JR (E) sets the PC to `reg[F2]`.
- R9: A branch or jump whose target equals its own address raises `halted`. After that, the PC and `halted` stay fixed and the core makes no further memory accesses until reset.
- R10: Instructions take these numbers of clock cycles: register ALU, immediate and SHIFT take 5; LW takes 6; SW takes 5; branches and jumps take 4.
- R11: `dbg_data` shows `reg[dbg_sel]` and `dbg_pc` shows the PC, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for a fetch or a data access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| dbg_sel | input | 4 | Register selected for the debug view |
| dbg_data | output | 16 | Contents of the selected register |
| dbg_pc | output | 16 | Current program counter |
| halted | output | 1 | Self-jump stop flag |

## Verification
The bench builds the core with `RESET_PC` set to 0x0010 instead of 0. This confirms that the start address comes from the parameter and is not a hard-wired zero. It also frees words 0 to 7 for data that LW and SW can reach with a zero base register and a positive offset. The bench memory decodes only the low 8 address bits. A negative offset from register 0 therefore wraps to the top of that array, which exercises sign extension of the address offset. Each scenario ends its program with a self-branch, so that results and cycle counts can be read after `halted` rises.

// File: rtl/mini16_core.sv
module mini16_core #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  input  logic [15:0] mem_rdata,
  input  logic [3:0]  dbg_sel,
  output logic [15:0] dbg_data,
  output logic [15:0] dbg_pc,
  output logic        halted
);
  localparam int W = 16;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_READ, S_EXE, S_MEM, S_WB, S_HALT} state_t;

  localparam logic [3:0] OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR = 4'h3,
                         OP_SLT = 4'h4, OP_ADDI = 4'h5, OP_ANDI = 4'h6, OP_ORI = 4'h7,
                         OP_SLTI = 4'h8, OP_LW = 4'h9, OP_SW = 4'hA, OP_BEQ = 4'hB,
                         OP_BNE = 4'hC, OP_SHF = 4'hD, OP_JR = 4'hE, OP_JAL = 4'hF;

  state_t       state;
  logic [W-1:0] pc, ir, ra, rb, res;
  logic [W-1:0] rf [16];
  logic [W-1:0] alu, imm_s, imm_z, tgt;
  logic [3:0]   op;
  logic         is_ctl;

  assign op     = ir[15:12];
  assign imm_s  = {{(W-4){ir[3]}}, ir[3:0]};
  assign imm_z  = {{(W-4){1'b0}}, ir[3:0]};
  assign is_ctl = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_JR) || (op == OP_JAL);

  assign mem_addr  = (state == S_MEM) ? res : pc;
  assign mem_wdata = rb;
  assign mem_we    = (state == S_MEM) && (op == OP_SW);
  assign dbg_data  = rf[dbg_sel];
  assign dbg_pc    = pc;
  assign halted    = (state == S_HALT);

  always_comb begin
    case (op)
      OP_ADD:  alu = ra + rb;
      OP_SUB:  alu = ra - rb;
      OP_AND:  alu = ra & rb;
      OP_OR:   alu = ra | rb;
      OP_SLT:  alu = {{(W-1){1'b0}}, $signed(ra) < $signed(rb)};
      OP_ADDI: alu = ra + imm_s;
      OP_ANDI: alu = ra & imm_z;
      OP_ORI:  alu = ra | imm_z;
      OP_SLTI: alu = {{(W-1){1'b0}}, $signed(ra) < $signed(imm_s)};
      OP_LW, OP_SW: alu = ra + imm_s;
      OP_SHF:
        case (ir[3:0])
          4'd0:    alu = {ra[W-2:0], 1'b0};
          4'd1:    alu = {1'b0, ra[W-1:1]};
          4'd2:    alu = {ra[W-1], ra[W-1:1]};
          4'd3:    alu = {ra[W-2:0], ra[W-1]};
          4'd4:    alu = {ra[0], ra[W-1:1]};
          default: alu = ra;
        endcase
      default: alu = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_BEQ:  tgt = ((rb - ra) == '0) ? pc + imm_s : pc;
      OP_BNE:  tgt = ((rb - ra) != '0) ? pc + imm_s : pc;
      OP_JR:   tgt = rb;
      OP_JAL:  tgt = {pc[W-1:12], ir[11:0]};
      default: tgt = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      ir    <= '0;
      ra    <= '0;
      rb    <= '0;
      res   <= '0;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_READ;
        end
        S_READ: begin
          ra    <= rf[ir[7:4]];
          rb    <= (op <= OP_SLT) ? rf[ir[3:0]] : rf[ir[11:8]];
          state <= S_EXE;
        end
        S_EXE: begin
          res <= alu;
          if (is_ctl) begin
            pc <= tgt;
            if (op == OP_JAL) rf[15] <= pc;
            state <= (tgt == pc - 1'b1) ? S_HALT : S_FETCH;
          end else if (op == OP_LW || op == OP_SW) begin
            state <= S_MEM;
          end else begin
            state <= S_WB;
          end
        end
        S_MEM: state <= (op == OP_LW) ? S_WB : S_FETCH;
        S_WB: begin
          rf[ir[11:8]] <= (op == OP_LW) ? mem_rdata : res;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc));

  a_r5_single_store: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r8_jal_link: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE && op == OP_JAL) |=> rf[15] == $past(pc));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE && op == OP_BEQ && ra != rb) |=> pc == $past(pc));

  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC) |=> pc == $past(pc) + 16'd1);

  a_r9_no_access: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
endmodule

// File: tb/mini16_core_tb.sv
module mini16_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START = 16'h0010;

  logic clk = 0, rst = 1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data, dbg_pc;
  logic mem_we, halted;
  logic [3:0] dbg_sel = 0;
  logic [15:0] mem [256];
  logic ld_we = 0;
  logic [7:0] ld_a = 0;
  logic [15:0] ld_d = 0;
  int checks = 0, errors = 0, we_cnt = 0, run_cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ld_we) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we && !rst) we_cnt <= we_cnt + 1;
  end

  mini16_core #(.RESET_PC(START)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .dbg_pc(dbg_pc), .halted(halted));

  function automatic logic [15:0] ins(input logic [3:0] op, a, b, c);
    return {op, a, b, c};
  endfunction

  localparam logic [15:0] HALT = 16'hB00F;

  task automatic chk(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); ld_we = 1; ld_a = a; ld_d = d;
    @(negedge clk); ld_we = 0;
  endtask

  task automatic clear_mem();
    rst = 1;
    for (int i = 0; i < 256; i++) put(i[7:0], 16'h0000);
    put(8'h00, 16'h1234); put(8'h01, 16'hF00F); put(8'h02, 16'hC002);
    put(8'h03, 16'h4001); put(8'h04, 16'h0030); put(8'hFF, 16'hBEEF);
  endtask

  task automatic run();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; we_cnt = 0; run_cycles = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      run_cycles++;
      if (halted) break;
    end
  endtask

  task automatic reg_is(input string req, input logic [3:0] r, input logic [15:0] exp);
    @(negedge clk); dbg_sel = r; #1;
    chk(req, dbg_data, exp);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", dbg_pc, START);
    chk("R1 halted", {15'b0, halted}, 16'h0);
    for (int r = 0; r < 16; r++) begin
      dbg_sel = r[3:0]; #1;
      chk("R1 R11 reg clear", dbg_data, 16'h0000);
    end
    rst = 0;
    #1 chk("R1 first fetch addr", mem_addr, START);
    @(negedge clk); rst = 1;
  endtask

  task automatic t_alu_reg();
    clear_mem();
    put(8'h10, ins(4'h9, 1, 0, 0)); put(8'h11, ins(4'h9, 2, 0, 1));
    put(8'h12, ins(4'h0, 3, 1, 2)); put(8'h13, ins(4'h1, 4, 1, 2));
    put(8'h14, ins(4'h2, 5, 1, 2)); put(8'h15, ins(4'h3, 6, 1, 2));
    put(8'h16, ins(4'h4, 7, 1, 2)); put(8'h17, ins(4'h4, 8, 2, 1));
    put(8'h18, HALT);
    run();
    reg_is("R2 ADD", 3, 16'h0243); reg_is("R2 SUB", 4, 16'h2225);
    reg_is("R2 AND", 5, 16'h1004); reg_is("R2 OR", 6, 16'hF23F);
    reg_is("R2 SLT false", 7, 16'h0000); reg_is("R2 SLT signed true", 8, 16'h0001);
  endtask

  task automatic t_alu_imm();
    clear_mem();
    put(8'h10, ins(4'h9, 1, 0, 0)); put(8'h11, ins(4'h5, 2, 1, 4'hF));
    put(8'h12, ins(4'h6, 3, 1, 4'hF)); put(8'h13, ins(4'h7, 4, 1, 4'h8));
    put(8'h14, ins(4'h8, 5, 1, 4'hF)); put(8'h15, ins(4'h8, 6, 0, 4'h1));
    put(8'h16, ins(4'h5, 7, 0, 4'h7)); put(8'h17, HALT);
    run();
    reg_is("R3 ADDI sext", 2, 16'h1233); reg_is("R3 ANDI zext", 3, 16'h0004);
    reg_is("R3 ORI zext", 4, 16'h123C); reg_is("R3 SLTI false", 5, 16'h0000);
    reg_is("R3 SLTI true", 6, 16'h0001); reg_is("R3 ADDI pos", 7, 16'h0007);
  endtask

  task automatic t_mem();
    clear_mem();
    put(8'h10, ins(4'h9, 1, 0, 4'hF)); put(8'h11, ins(4'h5, 2, 0, 4'h3));
    put(8'h12, ins(4'hA, 1, 2, 4'h2)); put(8'h13, ins(4'h9, 3, 0, 4'h5));
    put(8'h14, ins(4'hA, 2, 2, 4'hE)); put(8'h15, HALT);
    run();
    reg_is("R4 LW neg offset", 1, 16'hBEEF);
    reg_is("R4 LW after SW", 3, 16'hBEEF);
    chk("R5 SW word", mem[5], 16'hBEEF);
    chk("R5 SW neg offset", mem[1], 16'h0003);
    chk("R5 store strobes", we_cnt[15:0], 16'd2);
  endtask

  task automatic t_branch();
    clear_mem();
    put(8'h10, ins(4'h5, 1, 0, 1)); put(8'h11, ins(4'h5, 2, 0, 1));
    put(8'h12, ins(4'hB, 1, 2, 1)); put(8'h13, ins(4'h5, 3, 0, 5));
    put(8'h14, ins(4'hC, 1, 2, 1)); put(8'h15, ins(4'h5, 4, 0, 6));
    put(8'h16, ins(4'h5, 5, 0, 2));
    put(8'h17, ins(4'h5, 5, 5, 4'hF)); put(8'h18, ins(4'h5, 6, 6, 1));
    put(8'h19, ins(4'hC, 5, 0, 4'hD)); put(8'h1A, HALT);
    run();
    reg_is("R6 BEQ taken skips", 3, 16'h0000);
    reg_is("R6 BNE not taken", 4, 16'h0006);
    reg_is("R6 backward loop count", 6, 16'h0002);
    reg_is("R6 loop exit", 5, 16'h0000);
  endtask

  task automatic t_shift();
    clear_mem();
    put(8'h10, ins(4'h9, 1, 0, 2)); put(8'h11, ins(4'h9, 7, 0, 3));
    put(8'h12, ins(4'hD, 2, 1, 0)); put(8'h13, ins(4'hD, 3, 1, 1));
    put(8'h14, ins(4'hD, 4, 1, 2)); put(8'h15, ins(4'hD, 5, 1, 3));
    put(8'h16, ins(4'hD, 6, 7, 4)); put(8'h17, ins(4'hD, 8, 7, 9));
    put(8'h18, HALT);
    run();
    reg_is("R7 lsl", 2, 16'h8004); reg_is("R7 lsr", 3, 16'h6001);
    reg_is("R7 asr", 4, 16'hE001); reg_is("R7 rotl", 5, 16'h8005);
    reg_is("R7 rotr", 6, 16'hA000); reg_is("R7 other type", 8, 16'h4001);
  endtask

  task automatic t_jump();
    clear_mem();
    put(8'h10, 16'hF020); put(8'h11, ins(4'h5, 5, 0, 1));
    put(8'h20, ins(4'h9, 3, 0, 4)); put(8'h21, ins(4'hE, 3, 0, 0));
    put(8'h22, ins(4'h5, 6, 0, 1));
    put(8'h30, ins(4'h5, 4, 0, 1)); put(8'h31, HALT);
    run();
    reg_is("R8 JAL link", 15, 16'h0011);
    reg_is("R8 JAL skipped", 5, 16'h0000);
    reg_is("R8 JR skipped", 6, 16'h0000);
    reg_is("R8 JR target ran", 4, 16'h0001);
    chk("R9 halt pc", dbg_pc, 16'h0031);
  endtask

  task automatic t_halt();
    clear_mem();
    put(8'h10, 16'hF010); put(8'h11, ins(4'hA, 0, 0, 7));
    run();
    chk("R9 halted", {15'b0, halted}, 16'h1);
    chk("R9 halt pc", dbg_pc, 16'h0010);
    repeat (20) @(posedge clk);
    #1;
    chk("R9 stays halted", {15'b0, halted}, 16'h1);
    chk("R9 pc frozen", dbg_pc, 16'h0010);
    chk("R9 no store", we_cnt[15:0], 16'd0);
    reg_is("R8 R9 self JAL link", 15, 16'h0011);
  endtask

  task automatic t_cycles();
    clear_mem();
    put(8'h10, ins(4'h5, 1, 0, 2)); put(8'h11, ins(4'h9, 2, 0, 0));
    put(8'h12, ins(4'hA, 2, 0, 6)); put(8'h13, HALT);
    run();
    chk("R10 cycles ALU+LW+SW+branch", run_cycles[15:0], 16'd20);
    chk("R10 store done", mem[6], 16'h1234);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu_reg();
    t_alu_imm();
    t_mem();
    t_branch();
    t_shift();
    t_jump();
    t_halt();
    t_cycles();
    t_reset();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule